// File: doc/BRIEF.md
# SPI Master Register and FIFO Front End

This block is the register-facing half of an SPI master. A host reaches it through a generic register port with a byte address, a write strobe and a read strobe. The block holds the control/status word, the serial clock divider and the transfer length. One data address leads into two byte FIFOs. A write to that address queues a byte for transmission. A read from it takes the oldest received byte. A separate serial engine, which is not part of this block, takes transmit bytes and returns received bytes over two valid/ready byte channels. It also reports whether it is still shifting.

The control fields drive the engine through dedicated outputs: chip-select index and polarities, clock phase and polarity, transfer active, auto-deassert, read enable, long-data mode, divider and length. The status bits are computed live from the FIFO levels and the engine's busy line. The interrupt output combines a "done" condition with a receive high-water condition, each gated by its own enable. Flush bits in the control word empty either FIFO in the same write that changes other fields. The DMA-related addresses are reserved and read as zero.

Top module: `spi_regfront`

## Requirements
- R1: After reset every stored field is zero, a control read returns 0x00040000 (only TX-can-accept set), and `irq`, `tx_valid` and `xfer_active` are low.
- R2: The control word at byte address 0x00 uses these bit positions: [1:0] chip-select index, 2 clock phase, 3 clock polarity, 6 chip-select polarity, 7 transfer active, 9 done-interrupt enable, 10 RX-interrupt enable, 11 auto-deassert, 12 read enable, [23:21] per-line select polarity, 25 long-data mode. These bits read back as written. Bits 8, 13 and 24, and every bit above 25, read zero. The flush bits 4 (TX) and 5 (RX) always read zero.
- R3: A write to byte address 0x04 pushes its low byte into a 16-entry TX FIFO. A push into a full FIFO is dropped. Status bit 18 (TX can accept) is high exactly when fewer than 16 bytes are queued.
- R4: A read of 0x04 returns the oldest received byte in bits [7:0] and removes it. A read of an empty RX FIFO returns zero and changes nothing.
- R5: Status bit 17 is high when the RX FIFO holds at least one byte, bit 19 when it holds 12 or more, and bit 20 when it holds 16. `rx_ready` is low exactly when the RX FIFO is full, and a byte offered then is lost.
- R6: Status bit 16 (done) is high exactly when transfer-active is set, the TX FIFO is empty and `engine_busy` is low.
- R7: `irq` equals (done AND bit 9) OR (RX holds 12 or more AND bit 10). Setting transfer-active with bit 9 while the TX FIFO is empty raises it in the next cycle. Clearing bits 7, 9 and 10 together drops it.
- R8: Writing 1 to bit 4 or bit 5 of the control word empties the TX or RX FIFO on that edge. This takes precedence over a push or pop on the same edge, and the other fields of that write still take effect.
- R9: The divider at 0x08 and the length at 0x0C are 16-bit fields in bits [15:0]. Their upper bits read zero, and their values appear on `clk_div` and `xfer_len`.
- R10: Byte addresses 0x10 and 0x14, any address not in the map, and any address whose two low bits are nonzero read zero and ignore writes.
- R11: `tx_valid` is high only while transfer-active is set and the TX FIFO is not empty. `tx_data` is the oldest queued byte, and bytes leave in push order, one per cycle with `tx_valid` and `tx_ready` both high.
- R12: Writes to status bits 16 to 20 have no effect on the value read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at the data address) |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the strobe |
| irq | output | 1 | Interrupt request |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | RX FIFO has room |
| rx_data | input | 8 | Received byte |
| engine_busy | input | 1 | Engine is still shifting |
| xfer_active | output | 1 | Transfer-active field |
| cs_index | output | 2 | Chip-select index |
| spi_cpol | output | 1 | Clock polarity |
| spi_cpha | output | 1 | Clock phase |
| cs_active_high | output | 1 | Chip-select polarity |
| cs_line_pol | output | 3 | Per-line select polarity |
| auto_deassert | output | 1 | Auto-deassert select |
| read_enable | output | 1 | Read enable for shared-data-line mode |
| long_mode | output | 1 | Long-data mode |
| clk_div | output | 16 | Clock divider |
| xfer_len | output | 16 | Transfer length |

## Verification
The hardest states to reach from the ports are the FIFO edges: a full TX FIFO with extra pushes, a full RX FIFO with one byte still offered, and a flush arriving while both FIFOs hold data. The stimulus reaches them directly. It queues 18 bytes while transfer-active is clear, so nothing drains. It holds `rx_valid` for 17 cycles against a FIFO that fills after 16. It loads both FIFOs before one control write that sets both flush bits and enables transfer. The done-interrupt is shown both ways: with `engine_busy` held high after the TX FIFO drains, and after it drops. A behavioural model of queues and integers tracks every edge and compares the outputs on every cycle.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    // word index of each register (byte address / 4)
    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_DATA = 3'd1,
        RA_DIV  = 3'd2,
        RA_LEN  = 3'd3,
        RA_HOLD = 3'd4,
        RA_DMAC = 3'd5,
        RA_NONE = 3'd7
    } reg_idx_e;

    localparam int B_CLR_TX = 4;
    localparam int B_CLR_RX = 5;

    typedef struct packed {
        logic       long_mode;
        logic [2:0] line_pol;
        logic       read_en;
        logic       auto_cs;
        logic       irq_rx_en;
        logic       irq_done_en;
        logic       active;
        logic       cs_pol;
        logic       cpol;
        logic       cpha;
        logic [1:0] cs_idx;
    } ctrl_t;

    typedef struct packed {
        logic rx_full;
        logic rx_high;
        logic tx_room;
        logic rx_avail;
        logic done;
    } stat_t;

    function automatic reg_idx_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a[1:0] != 2'b00) return RA_NONE;
        return reg_idx_e'(a[ADDR_W-1:2]);
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.cs_idx      = w[1:0];
        c.cpha        = w[2];
        c.cpol        = w[3];
        c.cs_pol      = w[6];
        c.active      = w[7];
        c.irq_done_en = w[9];
        c.irq_rx_en   = w[10];
        c.auto_cs     = w[11];
        c.read_en     = w[12];
        c.line_pol    = w[23:21];
        c.long_mode   = w[25];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[1:0]   = c.cs_idx;
        w[2]     = c.cpha;
        w[3]     = c.cpol;
        w[6]     = c.cs_pol;
        w[7]     = c.active;
        w[9]     = c.irq_done_en;
        w[10]    = c.irq_rx_en;
        w[11]    = c.auto_cs;
        w[12]    = c.read_en;
        w[23:21] = c.line_pol;
        w[25]    = c.long_mode;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] pack_stat(input stat_t s);
        logic [REG_W-1:0] w;
        w     = '0;
        w[16] = s.done;
        w[17] = s.rx_avail;
        w[18] = s.tx_room;
        w[19] = s.rx_high;
        w[20] = s.rx_full;
        return w;
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo
    import spi_front_pkg::*;
#(
    parameter int W     = BYTE_W,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok, full;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wr_ptr] <= push_data;
    end

    // R3: a push into a full FIFO with no pop leaves it full
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (level == LW'(DEPTH)));

    // R8: flush empties the FIFO on the next cycle
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
    import spi_front_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_idx_e          idx,
    input  logic [REG_W-1:0]  wdata,
    output ctrl_t             ctrl,
    output logic [DIV_W-1:0]  clk_div,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              flush_tx,
    output logic              flush_rx
);
    ctrl_t wr_ctrl;
    logic  wr_ctrl_sel;

    assign wr_ctrl     = unpack_ctrl(wdata);
    assign wr_ctrl_sel = wr_en && (idx == RA_CTRL);
    // flush strobes live only for the write cycle, never stored
    assign flush_tx    = wr_ctrl_sel && wdata[B_CLR_TX];
    assign flush_rx    = wr_ctrl_sel && wdata[B_CLR_RX];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            clk_div  <= '0;
            xfer_len <= '0;
        end else if (wr_en) begin
            unique case (idx)
                RA_CTRL: ctrl     <= wr_ctrl;
                RA_DIV:  clk_div  <= wdata[DIV_W-1:0];
                RA_LEN:  xfer_len <= wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    // R9: divider only moves on a write to its own address
    a_r9_div_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && idx == RA_DIV) |=> $stable(clk_div));

endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
    import spi_front_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int RX_HI_MARK = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [BYTE_W-1:0]  tx_data,
    input  logic               rx_valid,
    output logic               rx_ready,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               engine_busy,
    output logic               xfer_active,
    output logic [1:0]         cs_index,
    output logic               spi_cpol,
    output logic               spi_cpha,
    output logic               cs_active_high,
    output logic [2:0]         cs_line_pol,
    output logic               auto_deassert,
    output logic               read_enable,
    output logic               long_mode,
    output logic [DIV_W-1:0]   clk_div,
    output logic [LEN_W-1:0]   xfer_len
);
    localparam int LW = $clog2(FIFO_DEPTH + 1);

    reg_idx_e          idx;
    ctrl_t             ctrl;
    stat_t             stat;
    logic              flush_tx, flush_rx;
    logic              data_wr, data_rd;
    logic [BYTE_W-1:0] tx_head, rx_head;
    logic [LW-1:0]     tx_level, rx_level;
    logic              tx_empty, rx_empty;

    assign idx     = decode_addr(reg_addr);
    assign data_wr = reg_wr && (idx == RA_DATA);
    assign data_rd = reg_rd && (idx == RA_DATA);

    spi_ctrl_regs #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .idx      (idx),
        .wdata    (reg_wdata),
        .ctrl     (ctrl),
        .clk_div  (clk_div),
        .xfer_len (xfer_len),
        .flush_tx (flush_tx),
        .flush_rx (flush_rx)
    );

    spi_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_tx),
        .push      (data_wr),
        .push_data (reg_wdata[BYTE_W-1:0]),
        .pop       (tx_valid && tx_ready),
        .head      (tx_head),
        .level     (tx_level),
        .empty     (tx_empty)
    );

    spi_byte_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_rx),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (data_rd),
        .head      (rx_head),
        .level     (rx_level),
        .empty     (rx_empty)
    );

    // engine side
    assign tx_valid = ctrl.active && !tx_empty;
    assign tx_data  = tx_head;
    assign rx_ready = (rx_level != LW'(FIFO_DEPTH));

    // live status
    always_comb begin
        stat.done     = ctrl.active && tx_empty && !engine_busy;
        stat.rx_avail = !rx_empty;
        stat.tx_room  = (tx_level != LW'(FIFO_DEPTH));
        stat.rx_high  = (rx_level >= LW'(RX_HI_MARK));
        stat.rx_full  = (rx_level == LW'(FIFO_DEPTH));
    end

    assign irq = (stat.done && ctrl.irq_done_en) || (stat.rx_high && ctrl.irq_rx_en);

    always_comb begin
        unique case (idx)
            RA_CTRL: reg_rdata = pack_ctrl(ctrl) | pack_stat(stat);
            RA_DATA: reg_rdata = rx_empty ? '0 : REG_W'(rx_head);
            RA_DIV:  reg_rdata = REG_W'(clk_div);
            RA_LEN:  reg_rdata = REG_W'(xfer_len);
            default: reg_rdata = '0;
        endcase
    end

    assign xfer_active    = ctrl.active;
    assign cs_index       = ctrl.cs_idx;
    assign spi_cpol       = ctrl.cpol;
    assign spi_cpha       = ctrl.cpha;
    assign cs_active_high = ctrl.cs_pol;
    assign cs_line_pol    = ctrl.line_pol;
    assign auto_deassert  = ctrl.auto_cs;
    assign read_enable    = ctrl.read_en;
    assign long_mode      = ctrl.long_mode;

    // R11: an offered byte stays put until the engine takes it
    a_r11_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !reg_wr) |=> (tx_valid && $stable(tx_data)));

    // R4: a pop of an empty RX FIFO reads zero
    a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
        (data_rd && rx_empty) |-> (reg_rdata == '0));

    // R5: a full RX FIFO refuses the engine
    a_r5_rx_backpressure: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && !data_rd) |=> !rx_ready);

endmodule

// File: tb/tb_spi_regfront.sv
module tb_spi_regfront;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 0, reg_rd = 0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tx_valid, rx_ready, xfer_active;
    logic        tx_ready = 0, rx_valid = 0, engine_busy = 0;
    logic [7:0]  tx_data, rx_data = '0;
    logic [1:0]  cs_index;
    logic        spi_cpol, spi_cpha, cs_active_high, auto_deassert, read_enable, long_mode;
    logic [2:0]  cs_line_pol;
    logic [15:0] clk_div, xfer_len;

    int checks = 0;
    int fails  = 0;
    int handed = 0;
    logic [7:0] last_tx = '0;

    localparam logic [31:0] WMASK = 32'h02E0_1ECF;

    always #10 clk = ~clk;

    spi_regfront dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .engine_busy(engine_busy), .xfer_active(xfer_active), .cs_index(cs_index),
        .spi_cpol(spi_cpol), .spi_cpha(spi_cpha), .cs_active_high(cs_active_high),
        .cs_line_pol(cs_line_pol), .auto_deassert(auto_deassert), .read_enable(read_enable),
        .long_mode(long_mode), .clk_div(clk_div), .xfer_len(xfer_len)
    );

    function automatic void check(input string tag, input string what,
                                  input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endfunction

    // ---------------- reference model ----------------
    logic [31:0] m_ctrl = '0;
    logic [15:0] m_div = '0, m_len = '0;
    logic [7:0]  txq[$];
    logic [7:0]  rxq[$];

    function automatic int widx(input logic [4:0] a);
        if (a[1:0] != 2'b00) return 7;
        return int'(a[4:2]);
    endfunction

    function automatic logic m_done();
        return m_ctrl[7] && (txq.size() == 0) && !engine_busy;
    endfunction

    function automatic logic [31:0] model_rdata(input logic [4:0] a);
        logic [31:0] w;
        case (widx(a))
            0: begin
                w = m_ctrl;
                w[16] = m_done();
                w[17] = rxq.size() > 0;
                w[18] = txq.size() < 16;
                w[19] = rxq.size() >= 12;
                w[20] = rxq.size() == 16;
            end
            1: w = (rxq.size() > 0) ? {24'd0, rxq[0]} : 32'd0;
            2: w = {16'd0, m_div};
            3: w = {16'd0, m_len};
            default: w = 32'd0;
        endcase
        return w;
    endfunction

    always @(posedge clk) begin : model_step
        logic tx_pop, tx_push, rx_pop, rx_push, fl_tx, fl_rx;
        if (rst) begin
            m_ctrl = '0; m_div = '0; m_len = '0;
            txq.delete(); rxq.delete();
        end else begin
            tx_pop  = m_ctrl[7] && txq.size() > 0 && tx_ready;
            tx_push = reg_wr && widx(reg_addr) == 1 && txq.size() < 16;
            rx_pop  = reg_rd && widx(reg_addr) == 1 && rxq.size() > 0;
            rx_push = rx_valid && rxq.size() < 16;
            fl_tx   = reg_wr && widx(reg_addr) == 0 && reg_wdata[4];
            fl_rx   = reg_wr && widx(reg_addr) == 0 && reg_wdata[5];
            if (fl_tx) txq.delete();
            else begin
                if (tx_pop)  void'(txq.pop_front());
                if (tx_push) txq.push_back(reg_wdata[7:0]);
            end
            if (fl_rx) rxq.delete();
            else begin
                if (rx_pop)  void'(rxq.pop_front());
                if (rx_push) rxq.push_back(rx_data);
            end
            if (reg_wr) begin
                case (widx(reg_addr))
                    0: m_ctrl = reg_wdata & WMASK;
                    2: m_div  = reg_wdata[15:0];
                    3: m_len  = reg_wdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison, mid-cycle
    always @(negedge clk) begin : model_cmp
        logic e_irq, e_txv;
        string tg;
        if (!rst) begin
            e_irq = (m_done() && m_ctrl[9]) || (rxq.size() >= 12 && m_ctrl[10]);
            e_txv = m_ctrl[7] && txq.size() > 0;
            check("R7", "irq vs model", {31'd0, irq}, {31'd0, e_irq});
            check("R11", "tx_valid vs model", {31'd0, tx_valid}, {31'd0, e_txv});
            if (e_txv) check("R11", "tx_data vs model", {24'd0, tx_data}, {24'd0, txq[0]});
            check("R5", "rx_ready vs model", {31'd0, rx_ready}, {31'd0, rxq.size() < 16});
            check("R9", "clk_div vs model", {16'd0, clk_div}, {16'd0, m_div});
            check("R2", "xfer_active vs model", {31'd0, xfer_active}, {31'd0, m_ctrl[7]});
            if (reg_rd) begin
                case (widx(reg_addr))
                    0: tg = "R2";
                    1: tg = "R4";
                    2, 3: tg = "R9";
                    default: tg = "R10";
                endcase
                check(tg, "rdata vs model", reg_rdata, model_rdata(reg_addr));
            end
            if (tx_valid && tx_ready) begin
                handed++;
                last_tx = tx_data;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        check(tag, "register read", reg_rdata, exp);
        @(posedge clk); #2;
        reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2 rst = 0;

        // R1 reset state
        @(negedge clk);
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check("R1", "tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        check("R1", "xfer_len after reset", {16'd0, xfer_len}, 32'd0);
        @(posedge clk); #2;
        rd_chk(5'h00, 32'h0004_0000, "R1");

        // R2 field layout, R7 immediate done interrupt
        wr(5'h00, 32'hFFFF_FFFF);
        rd_chk(5'h00, 32'h02E5_1ECF, "R2");
        check("R2", "cs_index", {30'd0, cs_index}, 32'd3);
        check("R2", "cs_line_pol", {29'd0, cs_line_pol}, 32'd7);
        check("R2", "long_mode", {31'd0, long_mode}, 32'd1);
        check("R7", "irq on active+done-enable with empty TX", {31'd0, irq}, 32'd1);
        wr(5'h00, 32'h0000_0000);
        @(negedge clk);
        check("R7", "irq after clearing active and enables", {31'd0, irq}, 32'd0);
        @(posedge clk); #2;

        // R12 status bits ignore writes
        wr(5'h00, 32'h001F_0000);
        rd_chk(5'h00, 32'h0004_0000, "R12");

        // R9 divider and length
        wr(5'h08, 32'hFFFF_1234);
        wr(5'h0C, 32'hABCD_0010);
        rd_chk(5'h08, 32'h0000_1234, "R9");
        rd_chk(5'h0C, 32'h0000_0010, "R9");
        check("R9", "xfer_len port", {16'd0, xfer_len}, 32'h10);

        // R10 reserved and misaligned addresses
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h09, 32'h0000_5555);
        rd_chk(5'h10, 32'd0, "R10");
        rd_chk(5'h14, 32'd0, "R10");
        rd_chk(5'h02, 32'd0, "R10");
        rd_chk(5'h08, 32'h0000_1234, "R10");

        // R3 fill TX past its depth while inactive
        for (int i = 0; i < 18; i++) wr(5'h04, 32'h40 + i);
        @(negedge clk);
        check("R11", "tx_valid while inactive", {31'd0, tx_valid}, 32'd0);
        @(posedge clk); #2;
        rd_chk(5'h00, 32'h0000_0000, "R3");

        // R11 handoff in order; R6 done waits for the engine
        engine_busy = 1;
        wr(5'h00, 32'h0000_0280);
        @(negedge clk);
        check("R11", "tx_valid once active", {31'd0, tx_valid}, 32'd1);
        check("R11", "first byte offered", {24'd0, tx_data}, 32'h40);
        @(posedge clk); #2;
        tx_ready = 1;
        idle(20);
        tx_ready = 0;
        check("R3", "bytes handed to engine", handed, 32'd16);
        check("R3", "last byte handed", {24'd0, last_tx}, 32'h4F);
        rd_chk(5'h00, 32'h0004_0280, "R6");
        engine_busy = 0;
        rd_chk(5'h00, 32'h0005_0280, "R6");
        check("R7", "irq on done", {31'd0, irq}, 32'd1);
        wr(5'h00, 32'h0000_0000);

        // R5 fill RX, one extra byte is lost
        for (int k = 0; k < 17; k++) begin
            rx_valid = 1; rx_data = 8'h80 + k[7:0];
            @(posedge clk); #2;
        end
        rx_valid = 0;
        @(negedge clk);
        check("R5", "rx_ready when full", {31'd0, rx_ready}, 32'd0);
        @(posedge clk); #2;
        rd_chk(5'h00, 32'h001E_0000, "R5");
        wr(5'h00, 32'h0000_0400);
        @(negedge clk);
        check("R7", "irq on RX high-water", {31'd0, irq}, 32'd1);
        @(posedge clk); #2;
        for (int i = 0; i < 5; i++) rd_chk(5'h04, 32'h80 + i, "R4");
        @(negedge clk);
        check("R5", "irq drops below 12 entries", {31'd0, irq}, 32'd0);
        @(posedge clk); #2;
        rd_chk(5'h00, 32'h0006_0400, "R5");
        for (int i = 5; i < 16; i++) rd_chk(5'h04, 32'h80 + i, "R4");
        rd_chk(5'h04, 32'd0, "R4");
        rd_chk(5'h00, 32'h0004_0400, "R4");

        // R8 flush both FIFOs in a write that also enables transfer
        wr(5'h00, 32'h0000_0000);
        for (int i = 0; i < 3; i++) wr(5'h04, 32'h11 + i);
        for (int k = 0; k < 3; k++) begin
            rx_valid = 1; rx_data = 8'hA0 + k[7:0];
            @(posedge clk); #2;
        end
        rx_valid = 0;
        wr(5'h00, 32'h0000_02B0);
        rd_chk(5'h00, 32'h0005_0280, "R8");
        check("R8", "irq after flush with active", {31'd0, irq}, 32'd1);
        check("R8", "tx_valid after flush", {31'd0, tx_valid}, 32'd0);
        rd_chk(5'h04, 32'd0, "R8");
        wr(5'h00, 32'h0000_0000);
        @(negedge clk);
        check("R7", "irq back to idle", {31'd0, irq}, 32'd0);
        @(posedge clk); #2;

        idle(2);
        finish_run();
    end
endmodule